// File: doc/BRIEF.md
# Command-and-Poll Memory Word Reader

This block puts a register-style read port in front of a word-addressed nonvolatile memory. A host writes one 32-bit command word that carries a word address and a start bit. The engine then runs the access on a simple request/acknowledge memory port whose latency can vary. When the word comes back, the engine sets a done flag and places the data in the upper half of the same register. The whole register stays visible at all times.

A sequencer wraps this port to fetch a run of consecutive words. It checks the request against the memory size and issues one command per word. It polls the done flag a bounded number of times for each word and delivers every word as a one-cycle beat. It ends with a completion pulse and a status code. On the first word whose done flag never shows up, it stops the rest of the run. While no run is active, the host may also issue single commands of its own.

Top module: `nvm_word_reader`

## Requirements
- R1: After reset the register view reads 0, `blkBusy`, `blkDone`, `wordValid` and `memReq` are low.
- R2: A host command with bit 0 (start) set starts one memory read of the word address in bits [15:2]: `memAddr` carries that address and `memReq` stays high until `memAck`.
- R3: When a read completes, register bit 1 (done) is 1, bits [31:16] hold the word read and bits [15:2] the address; bit 0 reads 1 while the read is in flight and 0 once it has finished.
- R4: A new command clears the done bit in the cycle after it is accepted; otherwise done stays set.
- R5: A host command without the start bit is ignored, as is any host command while a block read is busy or in the cycle a block read is requested.
- R6: A block read of `count` words from `offset` delivers exactly the words at offset, offset+1, ... in order, each as one `wordValid` beat with its address and data, never on two adjacent cycles.
- R7: A successful block read ends with a one-cycle `blkDone` and status 2'b00 in the same cycle as its last `wordValid`, after which `blkBusy` is low.
- R8: A request with offset ≥ WORD_COUNT, count = 0 or count > WORD_COUNT − offset is rejected: `blkDone` pulses with status 2'b01 the cycle after the request, with no memory access, no word and no busy cycle.
- R9: For each word the done bit is polled on at most POLL_LIMIT cycles. A done bit that first appears on the last permitted poll is still accepted.
- R10: If done is not seen within POLL_LIMIT polls, the run ends with `blkDone` and status 2'b10 and the remaining words are not fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host command write strobe |
| hostWord | input | 32 | Host command word (start bit 0, address bits [15:2]) |
| regView | output | 32 | Command/result register: data [31:16], address [15:2], done bit 1, in-flight bit 0 |
| blkStart | input | 1 | Block read request |
| blkOffset | input | 14 | First word address of the block |
| blkCount | input | 15 | Number of words in the block |
| blkBusy | output | 1 | Block read in progress |
| blkDone | output | 1 | One-cycle end-of-block pulse |
| blkStatus | output | 2 | 00 ok, 01 range reject, 10 timeout; valid with blkDone |
| wordValid | output | 1 | One-cycle beat carrying a fetched word |
| wordAddr | output | 14 | Address of the delivered word |
| wordData | output | 16 | Delivered word |
| memReq | output | 1 | Memory read request, held until acknowledged |
| memAddr | output | 14 | Memory word address |
| memAck | input | 1 | Memory acknowledge, one cycle, data valid |
| memData | input | 16 | Memory read data |

## Verification
The bench sweeps every legal offset and count of a 16-word memory whose latency changes with the address. An off-by-one in the word loop would drop or repeat the last word, and the sweep catches it. So does a stale done flag that lets the next word pass before its own read has finished. The range edges are probed one word inside and one word outside. A design that computed the remaining words wrongly would either fetch past the end or refuse a legal tail read. The poll limit is driven at its exact boundary: a latency that makes done appear on the final poll must succeed and one cycle more must time out, which exposes a counter that stops one poll early or late. A stalled word in the middle of a run must end it with the words before it delivered and none after.

// File: rtl/nvmrd_pkg.sv
package nvmrd_pkg;
  localparam int REG_W    = 32;
  localparam int START_BIT = 0;
  localparam int DONE_BIT  = 1;
  localparam int ADDR_LSB  = 2;
  localparam int DATA_LSB  = 16;
  localparam int ADDR_W    = DATA_LSB - ADDR_LSB;
  localparam int DATA_W    = REG_W - DATA_LSB;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_RANGE   = 2'b01,
    ST_TIMEOUT = 2'b10
  } blkStatus_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_ISSUE = 2'b01,
    SQ_POLL  = 2'b10
  } seqState_e;

  typedef struct packed {
    logic              issue;
    logic [ADDR_W-1:0] addr;
  } ctlStrobes_t;
endpackage

// File: rtl/nvmrd_datapath.sv
module nvmrd_datapath
  import nvmrd_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic                memAck,
  input  logic [DATA_W-1:0]   memData,
  output logic                dpDone,
  output logic [DATA_W-1:0]   dpData,
  output logic [REG_W-1:0]    regView
);
  logic              pending;
  logic              regDone;
  logic [ADDR_W-1:0] regAddr;
  logic [DATA_W-1:0] regData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      regDone <= 1'b0;
      regAddr <= '0;
      regData <= '0;
    end else if (ctl.issue) begin
      pending <= 1'b1;
      regDone <= 1'b0;
      regAddr <= ctl.addr;
    end else if (pending && memAck) begin
      pending <= 1'b0;
      regDone <= 1'b1;
      regData <= memData;
    end
  end

  assign memReq  = pending;
  assign memAddr = regAddr;
  assign dpDone  = regDone;
  assign dpData  = regData;

  always_comb begin
    regView                            = '0;
    regView[START_BIT]                 = pending;
    regView[DONE_BIT]                  = regDone;
    regView[ADDR_LSB +: ADDR_W]        = regAddr;
    regView[DATA_LSB +: DATA_W]        = regData;
  end

  // R4
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |=> !regView[DONE_BIT]);

  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !ctl.issue) |=> (memReq && $stable(memAddr)));

  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regView[DONE_BIT] && regView[START_BIT]));
endmodule

// File: rtl/nvmrd_control.sv
module nvmrd_control
  import nvmrd_pkg::*;
#(
  parameter int WORD_COUNT = 16384,
  parameter int POLL_LIMIT = 100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWr,
  input  logic [REG_W-1:0]    hostWord,
  input  logic                blkStart,
  input  logic [ADDR_W-1:0]   blkOffset,
  input  logic [ADDR_W:0]     blkCount,
  input  logic                dpDone,
  input  logic [DATA_W-1:0]   dpData,
  output ctlStrobes_t         ctl,
  output logic                blkBusy,
  output logic                blkDone,
  output logic [1:0]          blkStatus,
  output logic                wordValid,
  output logic [ADDR_W-1:0]   wordAddr,
  output logic [DATA_W-1:0]   wordData
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam logic [PCW-1:0] LAST_POLL = PCW'(POLL_LIMIT - 1);

  seqState_e          state;
  logic [ADDR_W-1:0]  curAddr;
  logic [ADDR_W:0]    left;
  logic [PCW-1:0]     pollCnt;
  logic               inRange;
  logic [31:0]        offWide;
  logic [31:0]        cntWide;

  assign offWide = 32'(blkOffset);
  assign cntWide = 32'(blkCount);

  always_comb begin
    inRange = 1'b0;
    if (offWide < 32'(WORD_COUNT) && cntWide != 32'd0)
      inRange = (cntWide <= 32'(WORD_COUNT) - offWide);
  end

  always_comb begin
    ctl.issue = 1'b0;
    ctl.addr  = hostWord[ADDR_LSB +: ADDR_W];
    if (state == SQ_ISSUE) begin
      ctl.issue = 1'b1;
      ctl.addr  = curAddr;
    end else if (state == SQ_IDLE && !blkStart && hostWr && hostWord[START_BIT]) begin
      ctl.issue = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SQ_IDLE;
      curAddr   <= '0;
      left      <= '0;
      pollCnt   <= '0;
      blkDone   <= 1'b0;
      blkStatus <= ST_OK;
      wordValid <= 1'b0;
      wordAddr  <= '0;
      wordData  <= '0;
    end else begin
      blkDone   <= 1'b0;
      wordValid <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (blkStart) begin
            if (inRange) begin
              curAddr <= blkOffset;
              left    <= blkCount;
              state   <= SQ_ISSUE;
            end else begin
              blkDone   <= 1'b1;
              blkStatus <= ST_RANGE;
            end
          end
        end
        SQ_ISSUE: begin
          pollCnt <= '0;
          state   <= SQ_POLL;
        end
        SQ_POLL: begin
          if (dpDone) begin
            wordValid <= 1'b1;
            wordAddr  <= curAddr;
            wordData  <= dpData;
            curAddr   <= curAddr + 1'b1;
            left      <= left - 1'b1;
            if (left == (ADDR_W+1)'(1)) begin
              blkDone   <= 1'b1;
              blkStatus <= ST_OK;
              state     <= SQ_IDLE;
            end else begin
              state <= SQ_ISSUE;
            end
          end else if (pollCnt == LAST_POLL) begin
            blkDone   <= 1'b1;
            blkStatus <= ST_TIMEOUT;
            state     <= SQ_IDLE;
          end else begin
            pollCnt <= pollCnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign blkBusy = (state != SQ_IDLE);

  // R9
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SQ_POLL) |-> (32'(pollCnt) < POLL_LIMIT));

  // R6
  beat_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |-> !blkBusy);

  // R8
  reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!blkBusy && blkStart && !inRange) |=> (blkDone && blkStatus == ST_RANGE && !blkBusy));
endmodule

// File: rtl/nvm_word_reader.sv
module nvm_word_reader
  import nvmrd_pkg::*;
#(
  parameter int WORD_COUNT = 16384,
  parameter int POLL_LIMIT = 100000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWr,
  input  logic [31:0]  hostWord,
  output logic [31:0]  regView,
  input  logic         blkStart,
  input  logic [13:0]  blkOffset,
  input  logic [14:0]  blkCount,
  output logic         blkBusy,
  output logic         blkDone,
  output logic [1:0]   blkStatus,
  output logic         wordValid,
  output logic [13:0]  wordAddr,
  output logic [15:0]  wordData,
  output logic         memReq,
  output logic [13:0]  memAddr,
  input  logic         memAck,
  input  logic [15:0]  memData
);
  ctlStrobes_t       ctl;
  logic              dpDone;
  logic [DATA_W-1:0] dpData;

  nvmrd_control #(
    .WORD_COUNT(WORD_COUNT),
    .POLL_LIMIT(POLL_LIMIT)
  ) uCtl (
    .clk(clk), .rstN(rstN),
    .hostWr(hostWr), .hostWord(hostWord),
    .blkStart(blkStart), .blkOffset(blkOffset), .blkCount(blkCount),
    .dpDone(dpDone), .dpData(dpData), .ctl(ctl),
    .blkBusy(blkBusy), .blkDone(blkDone), .blkStatus(blkStatus),
    .wordValid(wordValid), .wordAddr(wordAddr), .wordData(wordData)
  );

  nvmrd_datapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .dpDone(dpDone), .dpData(dpData), .regView(regView)
  );
endmodule

// File: tb/tb_nvm_word_reader.sv
`timescale 1ns/1ps
module tb_nvm_word_reader;
  localparam int WC = 16;
  localparam int PL = 20;

  logic clk = 0, rstN = 0;
  logic hostWr = 0;
  logic [31:0] hostWord = '0;
  logic [31:0] regView;
  logic blkStart = 0;
  logic [13:0] blkOffset = '0;
  logic [14:0] blkCount = '0;
  logic blkBusy, blkDone, wordValid, memReq, memAck;
  logic [1:0] blkStatus;
  logic [13:0] wordAddr, memAddr;
  logic [15:0] wordData, memData;

  int checks = 0, fails = 0, cycles = 0;
  int curOff = 0, gotWords = 0;
  int stallAddr = -1, stallLat = 0;
  int memCnt = 0;
  bit sawMem = 0, sawBusy = 0;

  always #5 clk = ~clk;

  nvm_word_reader #(.WORD_COUNT(WC), .POLL_LIMIT(PL)) dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostWord(hostWord), .regView(regView),
    .blkStart(blkStart), .blkOffset(blkOffset), .blkCount(blkCount),
    .blkBusy(blkBusy), .blkDone(blkDone), .blkStatus(blkStatus),
    .wordValid(wordValid), .wordAddr(wordAddr), .wordData(wordData),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData));

  function automatic logic [15:0] memFn(input int a);
    return 16'((a * 933 + 4660) ^ (a << 9));
  endfunction

  function automatic int latOf(input int a);
    return (a == stallAddr) ? stallLat : (a % 4);
  endfunction

  // memory model: acknowledges after latOf(addr) extra cycles
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAck <= 0; memData <= '0; memCnt <= 0;
    end else if (memAck) begin
      memAck <= 0; memCnt <= 0;
    end else if (memReq) begin
      if (memCnt == latOf(int'(memAddr))) begin
        memAck <= 1; memData <= memFn(int'(memAddr));
      end else memCnt <= memCnt + 1;
    end else memCnt <= 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      if (memReq) sawMem = 1;
      if (blkBusy) sawBusy = 1;
      if (wordValid) begin
        chk(int'(wordAddr) == curOff + gotWords, "R6 addr", 32'(wordAddr), 32'(curOff + gotWords));
        chk(wordData == memFn(curOff + gotWords), "R6 data", 32'(wordData), 32'(memFn(curOff + gotWords)));
        gotWords++;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runBlock(input int off, input int cnt, output logic [1:0] st);
    @(negedge clk);
    curOff = off; gotWords = 0; sawMem = 0; sawBusy = 0;
    blkStart = 1; blkOffset = 14'(off); blkCount = 15'(cnt);
    @(negedge clk);
    blkStart = 0;
    while (!blkDone) @(negedge clk);
    st = blkStatus;
    #1;
  endtask

  task automatic hostCmd(input logic [31:0] w);
    @(negedge clk);
    hostWr = 1; hostWord = w;
    @(negedge clk);
    hostWr = 0;
  endtask

  function automatic logic [31:0] cmdOf(input int a);
    return {16'h0, 14'(a), 1'b0, 1'b1};
  endfunction

  logic [1:0] st;
  logic [31:0] snap;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(regView == 0, "R1 regView", regView, 0);
    chk(!blkBusy && !blkDone && !wordValid && !memReq, "R1 flags",
        {28'h0, blkBusy, blkDone, wordValid, memReq}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2/R3 host single read
    hostCmd(cmdOf(5));
    chk(regView[0] == 1 && regView[1] == 0, "R3 in flight", regView, 32'h1);
    chk(memReq && memAddr == 14'd5, "R2 request", {17'h0, memReq, memAddr}, {17'h0, 1'b1, 14'd5});
    repeat (10) @(negedge clk);
    chk(regView == {memFn(5), 14'd5, 1'b1, 1'b0}, "R3 result", regView, {memFn(5), 14'd5, 2'b10});
    repeat (10) @(negedge clk);
    chk(regView[1] == 1, "R4 done sticky", regView, {memFn(5), 14'd5, 2'b10});

    // R4 new command clears done
    hostCmd(cmdOf(6));
    chk(regView[1:0] == 2'b01 && regView[15:2] == 14'd6, "R4 clear", regView, {16'h0, 14'd6, 2'b01});
    repeat (10) @(negedge clk);
    chk(regView == {memFn(6), 14'd6, 2'b10}, "R3 second", regView, {memFn(6), 14'd6, 2'b10});

    // R5 command without start bit ignored
    snap = regView;
    hostCmd({16'hFFFF, 14'd3, 2'b00});
    repeat (5) @(negedge clk);
    chk(regView == snap && !memReq, "R5 no start", regView, snap);

    // R6/R7 exhaustive sweep of legal blocks
    for (int off = 0; off < WC; off++) begin
      for (int cnt = 1; cnt <= WC - off; cnt++) begin
        runBlock(off, cnt, st);
        chk(st == 2'b00, "R7 status", 32'(st), 0);
        chk(gotWords == cnt, "R6 count", gotWords, cnt);
        chk(!blkBusy, "R7 idle", 32'(blkBusy), 0);
      end
    end

    // R5 host writes ignored while busy
    fork
      runBlock(0, 4, st);
      begin
        repeat (3) @(negedge clk);
        hostWr = 1; hostWord = cmdOf(9);
        @(negedge clk);
        hostWr = 0;
      end
    join
    chk(gotWords == 4 && st == 2'b00, "R5 busy run", gotWords, 4);
    repeat (8) @(negedge clk);
    chk(regView == {memFn(3), 14'd3, 2'b10}, "R5 busy ignored", regView, {memFn(3), 14'd3, 2'b10});

    // R8 range rejects
    runBlock(WC, 1, st);
    chk(st == 2'b01 && gotWords == 0 && !sawMem && !sawBusy, "R8 offset", 32'(st), 1);
    runBlock(3, 0, st);
    chk(st == 2'b01 && gotWords == 0 && !sawMem && !sawBusy, "R8 zero", 32'(st), 1);
    runBlock(10, WC - 10 + 1, st);
    chk(st == 2'b01 && gotWords == 0 && !sawMem && !sawBusy, "R8 tail", 32'(st), 1);
    runBlock(10, WC - 10, st);
    chk(st == 2'b00 && gotWords == WC - 10, "R8 tail legal", gotWords, WC - 10);

    // R9 done on the last permitted poll
    stallAddr = 5; stallLat = PL - 3;
    runBlock(5, 1, st);
    chk(st == 2'b00 && gotWords == 1, "R9 last poll", 32'(st), 0);
    repeat (5) @(negedge clk);
    stallLat = PL - 2;
    runBlock(5, 1, st);
    chk(st == 2'b10 && gotWords == 0, "R10 one late", 32'(st), 2);
    repeat (30) @(negedge clk);

    // R10 abort mid-run
    stallAddr = 4; stallLat = PL + 10;
    runBlock(2, 5, st);
    chk(st == 2'b10, "R10 status", 32'(st), 2);
    chk(gotWords == 2, "R10 words", gotWords, 2);
    sawMem = 0;
    repeat (40) @(negedge clk);
    chk(gotWords == 2 && !blkBusy, "R10 no more", gotWords, 2);
    stallAddr = -1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule